// File: doc/BRIEF.md
# Group-Gray Coded Running-Sum Accumulator

This block keeps a running total of incoming data words. Both the data input bus and the stored total use a group-Gray code: the word is cut into two-bit groups, starting at the least significant bit. Each group is Gray coded on its own, and the groups keep their binary weights relative to each other. Correlated data, such as a slowly changing sampled waveform, therefore toggles fewer lines on these heavily loaded buses than plain binary would.

Inside the block, XOR networks turn the input word and the stored total back into binary. A plain binary adder then combines them, and a second XOR network re-codes the sum before it goes into the register. Each accepted word is added modulo 2^N. A sticky flag records whether any addition carried out of the top group.

Top module: `hacc_top`

## Requirements
- R1: A synchronous active-high `rst` makes `accOut` all zeros and clears `ovfSticky` at the next rising edge.
- R2: When `inValid` is high and `rst` is low at a rising edge, `accOut` becomes the coded form of (decoded `accOut` + decoded `inData`) after that edge.
- R3: When `inValid` and `rst` are both low at a rising edge, `accOut` and `ovfSticky` keep their values.
- R4: Code: bits 2k+1 and 2k form group k. The upper bit of a group equals the binary upper bit, and the lower bit is the XOR of the two binary bits. For example, binary 3 is 16'h0002, binary 8 is 16'h000C, and binary 15 is 16'h000A.
- R5: The sum wraps modulo 2^N. With a total of 2^N-1, adding 1 yields all zeros.
- R6: `ovfSticky` goes high after any accepted addition whose binary sum is 2^N or more. After that it stays high until reset.
- R7: When `rst` and `inValid` are both high at an edge, reset wins and the word is discarded.
- R8: An accepted all-zero input word leaves `accOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Accept `inData` at this edge |
| inData | input | DATA_W | Group-Gray coded addend |
| accOut | output | DATA_W | Group-Gray coded running total |
| ovfSticky | output | 1 | Set on any carry out of the top group |

## Verification
Two things can happen in the same cycle. A wrapping addition must both zero the total and raise the sticky flag. A reset can also arrive together with a valid word. The bench first loads the total with all ones and then adds one, and it checks that the total is zero and the flag is high after that single edge. In a separate test it asserts reset while a non-zero word is valid, and it expects a zero total with the flag clear.

// File: rtl/hacc_pkg.sv
package hacc_pkg;
  typedef struct packed {
    logic clear;
    logic load;
  } hacc_strobe_t;
endpackage

// File: rtl/hacc_codec.sv
// Per-group transcoder: ENCODE=1 maps binary to group-Gray, ENCODE=0 the reverse.
module hacc_codec #(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 2,
  parameter bit ENCODE  = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NUM_GROUPS = DATA_W / GROUP_W;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    localparam int BASE = g * GROUP_W;
    if (ENCODE) begin : gEnc
      always_comb begin
        dout[BASE+GROUP_W-1] = din[BASE+GROUP_W-1];
        for (int j = 0; j < GROUP_W-1; j++)
          dout[BASE+j] = din[BASE+j] ^ din[BASE+j+1];
      end
    end else begin : gDec
      always_comb begin
        logic running;
        running = 1'b0;
        for (int j = GROUP_W-1; j >= 0; j--) begin
          running = running ^ din[BASE+j];
          dout[BASE+j] = running;
        end
      end
    end
  end
endmodule

// File: rtl/hacc_ctrl.sv
module hacc_ctrl
  import hacc_pkg::*;
(
  input  logic         rst,
  input  logic         inValid,
  output hacc_strobe_t stb
);
  always_comb begin
    stb.clear = rst;
    stb.load  = inValid & ~rst;
  end
endmodule

// File: rtl/hacc_datapath.sv
module hacc_datapath
  import hacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 2
) (
  input  logic              clk,
  input  hacc_strobe_t      stb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] accOut,
  output logic              ovfSticky
);
  logic [DATA_W-1:0] accReg, inBin, accBin, sumBin, sumHyb;
  logic              carryOut;

  hacc_codec #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .ENCODE(1'b0)) decIn_i (
    .din(inData), .dout(inBin));
  hacc_codec #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .ENCODE(1'b0)) decAcc_i (
    .din(accReg), .dout(accBin));

  always_comb begin
    {carryOut, sumBin} = {1'b0, accBin} + {1'b0, inBin};
  end

  hacc_codec #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .ENCODE(1'b1)) encSum_i (
    .din(sumBin), .dout(sumHyb));

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      accReg    <= '0;
      ovfSticky <= 1'b0;
    end else if (stb.load) begin
      accReg    <= sumHyb;
      ovfSticky <= ovfSticky | carryOut;
    end
  end

  assign accOut = accReg;
endmodule

// File: rtl/hacc_top.sv
module hacc_top
  import hacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] accOut,
  output logic              ovfSticky
);
  hacc_strobe_t stb;

  hacc_ctrl ctrl_i (.rst(rst), .inValid(inValid), .stb(stb));

  hacc_datapath #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) dp_i (
    .clk(clk), .stb(stb), .inData(inData), .accOut(accOut), .ovfSticky(ovfSticky));
endmodule

// File: rtl/hacc_chk.sv
module hacc_chk #(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic [DATA_W-1:0] accOut,
  input logic              ovfSticky
);
  function automatic logic [DATA_W-1:0] toBin(input logic [DATA_W-1:0] h);
    logic [DATA_W-1:0] b;
    for (int g = 0; g < DATA_W / GROUP_W; g++) begin
      logic r;
      r = 1'b0;
      for (int j = GROUP_W-1; j >= 0; j--) begin
        r = r ^ h[g*GROUP_W+j];
        b[g*GROUP_W+j] = r;
      end
    end
    return b;
  endfunction

  // R1, R7
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (accOut == '0) && !ovfSticky);
  // R2
  a_r2_sum: assert property (@(posedge clk) disable iff (rst)
    inValid |=> toBin(accOut) == DATA_W'(toBin($past(accOut)) + toBin($past(inData))));
  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(accOut) && $stable(ovfSticky));
  // R6
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    ovfSticky |=> ovfSticky);
  // R8
  a_r8_zero_word: assert property (@(posedge clk) disable iff (rst)
    inValid && (inData == '0) |=> $stable(accOut));
endmodule

bind hacc_top hacc_chk #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
  .accOut(accOut), .ovfSticky(ovfSticky));

// File: tb/hacc_top_tb_top.sv
module hacc_top_tb_top;
  localparam int W = 16;
  localparam int NSTIM = 16;
  // {valid, binary addend}: a coarse sampled sine with some idle slots
  localparam logic [W:0] STIM [NSTIM] = '{
    {1'b1, 16'h8000}, {1'b1, 16'hB0FB}, {1'b1, 16'hDA82}, {1'b0, 16'hF641},
    {1'b1, 16'hFFFF}, {1'b1, 16'hF641}, {1'b0, 16'h0000}, {1'b1, 16'hB0FB},
    {1'b1, 16'h8000}, {1'b1, 16'h4F05}, {1'b1, 16'h257E}, {1'b0, 16'h1234},
    {1'b1, 16'h0000}, {1'b1, 16'h09BF}, {1'b1, 16'h257E}, {1'b1, 16'h4F05}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, inValid, ovfSticky;
  logic [W-1:0] inData, accOut;
  int total = 0, bad = 0;
  logic [W-1:0] refSum;
  logic         refOvf;
  logic [31:0]  lfsr;

  hacc_top #(.DATA_W(W), .GROUP_W(2)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .accOut(accOut), .ovfSticky(ovfSticky));

  function automatic logic [W-1:0] toHyb(input logic [W-1:0] b);
    logic [W-1:0] h;
    for (int k = 0; k < W/2; k++) begin
      h[2*k+1] = b[2*k+1];
      h[2*k]   = b[2*k+1] ^ b[2*k];
    end
    return h;
  endfunction

  function automatic logic [W-1:0] fromHyb(input logic [W-1:0] h);
    logic [W-1:0] b;
    for (int k = 0; k < W/2; k++) begin
      b[2*k+1] = h[2*k+1];
      b[2*k]   = h[2*k+1] ^ h[2*k];
    end
    return b;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic v, input logic [W-1:0] bin);
    logic [W:0] wide;
    inValid = v;
    inData  = toHyb(bin);
    @(posedge clk);
    if (v) begin
      wide   = {1'b0, refSum} + {1'b0, bin};
      refSum = wide[W-1:0];
      refOvf = refOvf | wide[W];
    end
    @(negedge clk);
    check(req, fromHyb(accOut), refSum);
    check({req, " flag"}, {15'd0, ovfSticky}, {15'd0, refOvf});
  endtask

  task automatic doReset(input logic v, input logic [W-1:0] bin);
    rst = 1'b1; inValid = v; inData = toHyb(bin);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    refSum = '0; refOvf = 1'b0;
    check("R1 reset total", accOut, '0);
    check("R1 reset flag", {15'd0, ovfSticky}, 16'd0);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inData = '0; refSum = '0; refOvf = 1'b0;
    lfsr = 32'hACE1_2468;
    @(negedge clk);
    doReset(1'b0, '0);

    // R4: exact code values
    step("R4 code of 3", 1'b1, 16'd3);
    check("R4 raw 3", accOut, 16'h0002);
    step("R4 code of 8", 1'b1, 16'd5);
    check("R4 raw 8", accOut, 16'h000C);
    step("R4 code of 15", 1'b1, 16'd7);
    check("R4 raw 15", accOut, 16'h000A);

    // R2/R3 table walk
    doReset(1'b0, '0);
    for (int i = 0; i < NSTIM; i++)
      step(STIM[i][W] ? "R2 table add" : "R3 table hold", STIM[i][W], STIM[i][W-1:0]);

    // R2/R3 pseudo-random
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R2 random", lfsr[20] | lfsr[19], lfsr[15:0]);
    end

    // R5/R6: wrap and carry in the same edge
    doReset(1'b0, '0);
    step("R5 load max", 1'b1, 16'hFFFF);
    step("R5 wrap to zero", 1'b1, 16'h0001);
    check("R5 raw zero", accOut, '0);
    check("R6 flag set", {15'd0, ovfSticky}, 16'd1);
    step("R6 flag holds idle", 1'b0, 16'h5555);
    step("R6 flag holds add", 1'b1, 16'h0010);
    // R8: zero word
    step("R8 zero word", 1'b1, 16'h0000);
    check("R8 raw", accOut, toHyb(16'h0010));

    // R7: reset beats a valid word
    step("R7 preload", 1'b1, 16'h0777);
    doReset(1'b1, 16'h1357);
    check("R7 word dropped", accOut, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule